// File: doc/BRIEF.md
# MII Nibble Transmit Framer

This block sits between an Ethernet MAC that delivers transmit data four bits at a time and the serializer of a point-to-point link. It turns each frame into a stream of 5-bit code groups. Between frames it sends Idle code groups. The first two nibbles of every frame become a start delimiter. A two-code-group end delimiter follows the last nibble. A nibble flagged as bad by the MAC is replaced by a HALT code group. Everything runs on one clock, and all inputs are sampled on its rising edge.

The MAC is paced by a read-request output. A cycle in which read-request is high is an accepted cycle: the framer consumes the MAC's enable, error and nibble, and it emits exactly one code group after that clock edge. The link side can stall the framer through a ready input. While the link is not ready, read-request is low. The MAC must then hold its current nibble, and the framer consumes nothing and emits nothing new. A frame must span at least three accepted enable-high cycles. The enable must be low in the two accepted cycles after a frame ends.

Top module: `mii_tx_framer`

## Requirements
- R1: While the synchronous active-low reset is low, read-request is low at once. After a clock edge with reset low, the code output is Idle (11111) and the valid flag is low.
- R2: Read-request is high exactly when reset is high, reset was also high at the previous clock edge, and link-ready is high. It therefore stays high during the two accepted cycles that follow the fall of transmit-enable.
- R3: An accepted cycle with transmit-enable low outside a frame tail yields Idle (11111), whatever the nibble and error inputs carry.
- R4: The first accepted cycle with transmit-enable high yields J (11000), and the next accepted cycle yields K (10001). The nibble and error inputs of these two cycles have no effect.
- R5: From the third accepted enable-high cycle of a frame, the nibble is coded as 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R6: A body nibble accepted with the error input high yields HALT (00100) instead of its data code.
- R7: The first accepted cycle with transmit-enable low after a frame body yields T (01101), and the next accepted cycle yields R (00111). The accepted cycle after R may start a new frame with J.
- R8: Each code group appears with the valid flag high right after the clock edge of its accepted cycle. After a clock edge of a cycle that was not accepted, the valid flag is low, the code output holds its previous value, and the frame resumes unchanged at the next accepted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| link_ready | input | 1 | Link side can take a code group this cycle |
| mii_tx_en | input | 1 | MAC transmit enable, high while a frame is offered |
| mii_tx_er | input | 1 | MAC coding-error flag for the current nibble |
| mii_txd | input | 4 | MAC transmit nibble |
| mii_rd_req | output | 1 | Read request; high in cycles the framer accepts the inputs |
| cg_data | output | 5 | Emitted 4B/5B code group |
| cg_valid | output | 1 | cg_data carries a new code group this cycle |

## Verification
The hardest case to reach is a stall that lands inside a frame, for instance in the middle of the body or on the T or R tail. A correct result there needs the framer to hold both its position in the frame and its output. The MAC model in the bench must also keep its nibble through the stall. A directed pass drops link-ready for three cycles exactly when the fifth nibble of a frame is presented. A long random pass then drops link-ready on about one cycle in six, so stalls also fall on the J, K, T and R cycles. Back-to-back frames with the minimum two-cycle gap, a fixed error nibble in mid-frame, and a reset in the middle of a frame each get their own directed pass. Every cycle's code group is compared in order against a value that the bench derives from its own record of what it offered.

// File: rtl/txf_pkg.sv
// Package: shared widths, code-group constants, state and selector types,
// and the nibble-to-code-group data table used by the transmit framer.
package txf_pkg;

    localparam int NIB_W = 4;
    localparam int CG_W  = 5;

    localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
    localparam logic [CG_W-1:0] CG_J    = 5'b11000;
    localparam logic [CG_W-1:0] CG_K    = 5'b10001;
    localparam logic [CG_W-1:0] CG_T    = 5'b01101;
    localparam logic [CG_W-1:0] CG_R    = 5'b00111;
    localparam logic [CG_W-1:0] CG_HALT = 5'b00100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SOPK,
        ST_BODY,
        ST_EOPR
    } txf_state_e;

    typedef enum logic [2:0] {
        SEL_IDLE,
        SEL_J,
        SEL_K,
        SEL_DATA,
        SEL_T,
        SEL_R
    } txf_sel_e;

    // Map one data nibble to its 4B/5B data code group.
    function automatic logic [CG_W-1:0] nib_to_cg(input logic [NIB_W-1:0] nib);
        logic [CG_W-1:0] cg;
        case (nib)
            4'h0: cg = 5'b11110;
            4'h1: cg = 5'b01001;
            4'h2: cg = 5'b10100;
            4'h3: cg = 5'b10101;
            4'h4: cg = 5'b01010;
            4'h5: cg = 5'b01011;
            4'h6: cg = 5'b01110;
            4'h7: cg = 5'b01111;
            4'h8: cg = 5'b10010;
            4'h9: cg = 5'b10011;
            4'hA: cg = 5'b10110;
            4'hB: cg = 5'b10111;
            4'hC: cg = 5'b11010;
            4'hD: cg = 5'b11011;
            4'hE: cg = 5'b11100;
            default: cg = 5'b11101;
        endcase
        return cg;
    endfunction

endpackage

// File: rtl/txf_handshake.sv
// Read-request generator.
// Does: raises the read request toward the MAC when the framer is out of
// reset and the link can take a code group; that same signal marks the
// cycles in which the framer consumes its inputs.
// Assumes: rst_n is synchronous; link_ready is stable around the clock edge.
module txf_handshake (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ready,
    output logic rd_req
);

    logic run_q;

    // Remember that at least one edge has passed with reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
        end
    end

    // Request data only when running, out of reset and the link is ready.
    assign rd_req = run_q & link_ready & rst_n;

    AST_RDREQ_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && link_ready) |-> rd_req); // R2

endmodule

// File: rtl/txf_frame_fsm.sv
// Frame position tracker.
// Does: follows the MAC's transmit enable across accepted cycles and picks
// which code group the current accepted cycle produces (Idle, J, K, data,
// T or R).
// Assumes: a frame spans at least three accepted enable-high cycles, and
// enable is low in the two accepted cycles after a frame ends.
module txf_frame_fsm
    import txf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       tx_en,
    output txf_state_e st_q,
    output txf_sel_e   sel
);

    txf_state_e st_d;

    // Choose the output code and the next position for this cycle.
    always_comb begin
        st_d = st_q;
        sel  = SEL_IDLE;
        case (st_q)
            ST_IDLE: begin
                if (tx_en) begin
                    sel  = SEL_J;
                    st_d = ST_SOPK;
                end
            end
            ST_SOPK: begin
                sel  = SEL_K;
                st_d = ST_BODY;
            end
            ST_BODY: begin
                if (tx_en) begin
                    sel = SEL_DATA;
                end else begin
                    sel  = SEL_T;
                    st_d = ST_EOPR;
                end
            end
            default: begin
                sel  = SEL_R;
                st_d = ST_IDLE;
            end
        endcase
    end

    // Advance the frame position only on accepted cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else if (step) begin
            st_q <= st_d;
        end
    end

    AST_TAIL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q == ST_EOPR) |=> st_q == ST_IDLE); // R7

    AST_STALL_KEEPS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && $past(rst_n)) |=> $stable(st_q)); // R8

endmodule

// File: rtl/txf_cg_encoder.sv
// Code-group encoder.
// Does: turns the selector from the frame tracker, the nibble and the error
// flag into one 5-bit code group; a body nibble with the error flag set
// becomes HALT.
// Assumes: purely combinational; the caller registers the result.
module txf_cg_encoder
    import txf_pkg::*;
(
    input  txf_sel_e          sel,
    input  logic [NIB_W-1:0]  nib,
    input  logic              err,
    output logic [CG_W-1:0]   cg
);

    // Pick the control code or the coded nibble.
    always_comb begin
        case (sel)
            SEL_J:    cg = CG_J;
            SEL_K:    cg = CG_K;
            SEL_DATA: cg = err ? CG_HALT : nib_to_cg(nib);
            SEL_T:    cg = CG_T;
            SEL_R:    cg = CG_R;
            default:  cg = CG_IDLE;
        endcase
    end

endmodule

// File: rtl/mii_tx_framer.sv
// Nibble transmit framer, top level.
// Does: accepts MAC nibbles under a read-request handshake and emits one
// registered 4B/5B code group per accepted cycle, with Idle fill, J/K start
// and T/R end delimiters and HALT substitution for flagged nibbles.
// Assumes: single clock; synchronous active-low reset; the MAC holds its
// inputs in any cycle where the read request is low.
module mii_tx_framer
    import txf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_ready,
    input  logic             mii_tx_en,
    input  logic             mii_tx_er,
    input  logic [NIB_W-1:0] mii_txd,
    output logic             mii_rd_req,
    output logic [CG_W-1:0]  cg_data,
    output logic             cg_valid
);

    logic            step;
    txf_state_e      st_q;
    txf_sel_e        sel;
    logic [CG_W-1:0] cg_next;

    txf_handshake u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_ready (link_ready),
        .rd_req     (step)
    );

    txf_frame_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .tx_en (mii_tx_en),
        .st_q  (st_q),
        .sel   (sel)
    );

    txf_cg_encoder u_enc (
        .sel (sel),
        .nib (mii_txd),
        .err (mii_tx_er),
        .cg  (cg_next)
    );

    assign mii_rd_req = step;

    // Register one code group per accepted cycle; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cg_data  <= CG_IDLE;
            cg_valid <= 1'b0;
        end else begin
            cg_valid <= step;
            if (step) begin
                cg_data <= cg_next;
            end
        end
    end

    AST_STALL_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> (!cg_valid && $stable(cg_data))); // R8

    AST_SOP_J: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q == ST_IDLE && mii_tx_en) |=> (cg_valid && cg_data == CG_J)); // R4

    AST_SOP_K: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q == ST_SOPK) |=> (cg_valid && cg_data == CG_K)); // R4

    AST_HALT_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q == ST_BODY && mii_tx_en && mii_tx_er) |=> cg_data == CG_HALT); // R6

    AST_EOP_T: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q == ST_BODY && !mii_tx_en) |=> cg_data == CG_T); // R7

    AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q == ST_IDLE && !mii_tx_en) |=> cg_data == CG_IDLE); // R3

endmodule

// File: tb/mii_tx_framer_tb.sv
`timescale 1ns/1ps
module mii_tx_framer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_ready = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       rd_req;
    logic [4:0] cg;
    logic       cgv;

    always #2.5 clk = ~clk;

    mii_tx_framer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_ready (link_ready),
        .mii_tx_en  (tx_en),
        .mii_tx_er  (tx_er),
        .mii_txd    (txd),
        .mii_rd_req (rd_req),
        .cg_data    (cg),
        .cg_valid   (cgv)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expectation for the next negedge
    bit         have_exp = 0;
    logic [4:0] exp_code;
    logic       exp_valid;
    string      exp_tag;
    logic [4:0] last_code = 5'b11111;
    bit         prev_rst = 0;

    // MAC model
    bit         in_frame = 0;
    int         pos = 0;
    int         flen = 0;
    int         low_after = 2;
    int         gap_need = 2;
    logic [3:0] nib [16];
    bit         erb [16];
    bit         frames_on = 0;

    // knobs
    int bp_pct = 0;
    int err_pct = 0;
    int gap_min = 2, gap_max = 2;
    int len_min = 6, len_max = 6;
    int fixed_err_pos = -1;
    int bp_at_pos = -1;
    int bp_len = 3;
    int bp_hold = 0;
    bit bp_used = 0;

    // 4B/5B data codes as listed in R5
    function automatic logic [4:0] ref_cg(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic start_frame();
        flen = len_min + int'($urandom % (len_max - len_min + 1));
        for (int i = 0; i < 16; i++) begin
            nib[i] = 4'($urandom);
            erb[i] = (i == fixed_err_pos) || (int'($urandom % 100) < err_pct);
        end
        in_frame = 1;
        pos = 0;
        bp_used = 0;
        gap_need = gap_min + int'($urandom % (gap_max - gap_min + 1));
    endtask

    task automatic one_cycle(input bit rst_val);
        @(negedge clk);
        if (have_exp) begin
            chk(exp_tag, {3'b0, cg}, {3'b0, exp_code});
            chk(exp_tag, {7'b0, cgv}, {7'b0, exp_valid});
        end
        rst_n = rst_val;
        if (bp_hold > 0) begin
            link_ready = 1'b0;
            bp_hold--;
        end else if (in_frame && pos == bp_at_pos && !bp_used) begin
            bp_used = 1;
            link_ready = 1'b0;
            bp_hold = bp_len - 1;
        end else begin
            link_ready = (int'($urandom % 100) >= bp_pct);
        end
        if (in_frame) begin
            tx_en = 1'b1;
            txd = nib[pos];
            tx_er = erb[pos];
        end else begin
            tx_en = 1'b0;
            txd = 4'($urandom);
            tx_er = 1'($urandom);
        end
        #1;
        chk("R2", {7'b0, rd_req}, {7'b0, (rst_val && prev_rst && link_ready)});
        if (!rst_val) begin
            chk("R1", {7'b0, rd_req}, 8'd0);
            exp_code = 5'b11111; exp_valid = 1'b0; exp_tag = "R1";
            last_code = 5'b11111;
            in_frame = 0; low_after = 2;
        end else if (rd_req) begin
            exp_valid = 1'b1;
            if (in_frame) begin
                if (pos == 0) begin exp_code = 5'b11000; exp_tag = "R4"; end
                else if (pos == 1) begin exp_code = 5'b10001; exp_tag = "R4"; end
                else if (erb[pos]) begin exp_code = 5'b00100; exp_tag = "R6"; end
                else begin exp_code = ref_cg(nib[pos]); exp_tag = "R5"; end
                pos++;
                if (pos == flen) begin in_frame = 0; low_after = 0; end
            end else begin
                if (low_after == 0) begin exp_code = 5'b01101; exp_tag = "R7"; end
                else if (low_after == 1) begin exp_code = 5'b00111; exp_tag = "R7"; end
                else begin exp_code = 5'b11111; exp_tag = "R3"; end
                if (low_after < 100) low_after++;
                if (frames_on && low_after >= gap_need) start_frame();
            end
            last_code = exp_code;
        end else begin
            exp_code = last_code; exp_valid = 1'b0; exp_tag = "R8";
        end
        have_exp = 1;
        prev_rst = rst_val;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) one_cycle(1'b1);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 3; i++) one_cycle(1'b0);
        // R3: idle fill with no frames
        run(10);
        // R7: back-to-back frames with minimum gap
        frames_on = 1; gap_min = 2; gap_max = 2; len_min = 6; len_max = 6;
        run(60);
        // R6: fixed error nibble in mid-frame
        fixed_err_pos = 4;
        run(40);
        fixed_err_pos = -1;
        // R8: stall of three cycles at the fifth nibble
        bp_at_pos = 4; bp_len = 3;
        run(60);
        bp_at_pos = -1;
        // R1: reset in mid-frame, then resume
        run(3);
        for (int i = 0; i < 2; i++) one_cycle(1'b0);
        run(40);
        // random mix: stalls, errors, gaps, lengths
        bp_pct = 16; err_pct = 8; gap_min = 2; gap_max = 5; len_min = 3; len_max = 14;
        run(4000);
        frames_on = 0; bp_pct = 0;
        run(30);
        @(negedge clk);
        chk(exp_tag, {3'b0, cg}, {3'b0, exp_code});
        chk(exp_tag, {7'b0, cgv}, {7'b0, exp_valid});
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule